// File: doc/BRIEF.md
# Pipeline hazard and forwarding unit

This block is the operand-steering and stall controller for a five-stage in-order pipeline made up of fetch, decode/register read, execute, memory access and write back. Each cycle it compares register numbers held in different stage registers. The two execute-stage source operands each get a bypass select, so a result made in the execute or memory stage reaches a dependent instruction without waiting for write back. The two decode-stage register reads each get a flag that marks a same-cycle write from write back, so the read returns the value being written.

The block also catches the case that bypassing cannot fix. A load sitting in execute whose destination is read by the instruction in decode forces a one-cycle stall. During that cycle the program counter and the fetch/decode register hold their values, and the control bits that enter execute are cleared, so the slot becomes a bubble that writes nothing. A two-state machine records that a stall has just been issued. This keeps the stall to exactly one cycle, because by the next cycle the load has moved on to the memory stage.

Top module: `hazard_fwd_unit`

## Requirements
- R1: When the memory-stage instruction writes (mem_we=1) a non-zero register equal to an execute-stage source, that operand's select is 2'b10.
- R2: When only the write-back instruction writes (wb_we=1) a non-zero register equal to an execute-stage source, that operand's select is 2'b01.
- R3: When both the memory-stage and write-back destinations match the same source, the select is 2'b10, so the younger result wins.
- R4: A destination of register 0, or a low write enable, never produces a bypass. With no qualifying match the select is 2'b00, which picks the register-file value.
- R5: id_byp_a (id_byp_b) is 1 exactly when wb_we=1, wb_rd is non-zero and wb_rd equals id_rs1 (id_rs2).
- R6: A load-use hazard exists when ex_memrd=1, ex_rd is non-zero, and ex_rd equals id_rs1 or id_rs2. In the same cycle, pc_hold, ifid_hold and ctrl_zero are then all 1.
- R7: With no load-use hazard (ex_memrd=0, ex_rd=0, or no match), pc_hold, ifid_hold and ctrl_zero are 0.
- R8: A stall lasts one cycle. In the cycle after a stall, no stall is raised even if the hazard inputs are unchanged. The cycle after that may stall again.
- R9: After reset, with all inputs zero, every output is 0 and the controller is in the run state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs1 | input | REG_AW | First source register of the instruction in decode |
| id_rs2 | input | REG_AW | Second source register of the instruction in decode |
| ex_rs1 | input | REG_AW | First source register of the instruction in execute |
| ex_rs2 | input | REG_AW | Second source register of the instruction in execute |
| ex_rd | input | REG_AW | Destination register of the instruction in execute |
| ex_memrd | input | 1 | Instruction in execute reads memory (load) |
| mem_rd | input | REG_AW | Destination register in the memory stage |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | REG_AW | Destination register in write back |
| wb_we | input | 1 | Write-back instruction writes a register |
| fwd_a | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 write back |
| fwd_b | output | 2 | Operand B select, same encoding |
| id_byp_a | output | 1 | Decode read 1 takes the write-back value |
| id_byp_b | output | 1 | Decode read 2 takes the write-back value |
| pc_hold | output | 1 | Hold the program counter |
| ifid_hold | output | 1 | Hold the fetch/decode register |
| ctrl_zero | output | 1 | Clear control bits entering execute (bubble) |

## Verification
A load-use stall and operand bypassing can occur in the same cycle. The load in execute matches a decode source while the memory-stage and write-back destinations match the execute sources. The random phase uses register numbers drawn from a small range, so such overlaps happen often, and a directed case forces all three matches together. Each cycle the bench works out the selects and the stall from its own model. That model includes a one-cycle memory of the previous stall, and the two sets of outputs are judged separately.

// File: rtl/hfu_pkg.sv
package hfu_pkg;
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HELD = 1'b1
    } hz_state_e;
endpackage

// File: rtl/fwd_sel.sv
module fwd_sel #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_we,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_we,
    output logic [1:0]        sel
);
    import hfu_pkg::*;
    localparam logic [REG_AW-1:0] R_ZERO = '0;

    logic mem_hit, wb_hit;
    fwd_sel_e pick;

    assign mem_hit = mem_we && (mem_rd != R_ZERO) && (mem_rd == src);
    assign wb_hit  = wb_we  && (wb_rd  != R_ZERO) && (wb_rd  == src);

    always_comb begin
        if (mem_hit)     pick = SEL_MEM;
        else if (wb_hit) pick = SEL_WB;
        else             pick = SEL_RF;
    end

    assign sel = pick;
endmodule

// File: rtl/rf_bypass.sv
module rf_bypass #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] rd_addr,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_we,
    output logic              hit
);
    localparam logic [REG_AW-1:0] R_ZERO = '0;
    assign hit = wb_we && (wb_rd != R_ZERO) && (wb_rd == rd_addr);
endmodule

// File: rtl/loaduse_fsm.sv
module loaduse_fsm #(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_memrd,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    output logic              stall
);
    import hfu_pkg::*;
    localparam logic [REG_AW-1:0] R_ZERO = '0;

    hz_state_e state, state_nx;
    logic      hazard;

    assign hazard = ex_memrd && (ex_rd != R_ZERO) &&
                    ((ex_rd == id_rs1) || (ex_rd == id_rs2));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        stall    = 1'b0;
        unique case (state)
            ST_RUN: begin
                stall = hazard;
                if (hazard) state_nx = ST_HELD;
            end
            ST_HELD: begin
                stall    = 1'b0;
                state_nx = ST_RUN;
            end
        endcase
    end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_memrd,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_we,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_we,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic              id_byp_a,
    output logic              id_byp_b,
    output logic              pc_hold,
    output logic              ifid_hold,
    output logic              ctrl_zero
);
    localparam int NOPS = 2;

    logic [REG_AW-1:0] ex_src [NOPS];
    logic [REG_AW-1:0] id_src [NOPS];
    logic [1:0]        sel    [NOPS];
    logic              byp    [NOPS];
    logic              stall;

    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;
    assign id_src[0] = id_rs1;
    assign id_src[1] = id_rs2;

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        fwd_sel #(.REG_AW(REG_AW)) fwd_i (
            .src(ex_src[g]), .mem_rd(mem_rd), .mem_we(mem_we),
            .wb_rd(wb_rd), .wb_we(wb_we), .sel(sel[g])
        );
        rf_bypass #(.REG_AW(REG_AW)) byp_i (
            .rd_addr(id_src[g]), .wb_rd(wb_rd), .wb_we(wb_we), .hit(byp[g])
        );
    end

    loaduse_fsm #(.REG_AW(REG_AW)) lu_i (
        .clk(clk), .rst_n(rst_n), .ex_memrd(ex_memrd), .ex_rd(ex_rd),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .stall(stall)
    );

    assign fwd_a     = sel[0];
    assign fwd_b     = sel[1];
    assign id_byp_a  = byp[0];
    assign id_byp_b  = byp[1];
    assign pc_hold   = stall;
    assign ifid_hold = stall;
    assign ctrl_zero = stall;
endmodule

// File: rtl/hazard_fwd_chk.sv
module hazard_fwd_chk #(
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] id_rs1,
    input logic [REG_AW-1:0] ex_rs1,
    input logic [REG_AW-1:0] ex_rd,
    input logic              ex_memrd,
    input logic [REG_AW-1:0] mem_rd,
    input logic              mem_we,
    input logic [REG_AW-1:0] wb_rd,
    input logic              wb_we,
    input logic [1:0]        fwd_a,
    input logic [1:0]        fwd_b,
    input logic              id_byp_a,
    input logic              pc_hold,
    input logic              ctrl_zero
);
    a_r3_mem_first: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_rd != '0 && mem_rd == ex_rs1) |-> fwd_a == 2'b10);
    a_r4_no_writer: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we && !wb_we) |-> (fwd_a == 2'b00 && fwd_b == 2'b00));
    a_r5_byp_cause: assert property (@(posedge clk) disable iff (!rst_n)
        id_byp_a |-> (wb_we && wb_rd != '0 && wb_rd == id_rs1));
    a_r6_bubble_with_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> ctrl_zero);
    a_r7_stall_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> (ex_memrd && ex_rd != '0));
    a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |=> !pc_hold);
endmodule

bind hazard_fwd_unit hazard_fwd_chk #(.REG_AW(REG_AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .ex_rs1(ex_rs1), .ex_rd(ex_rd),
    .ex_memrd(ex_memrd), .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd),
    .wb_we(wb_we), .fwd_a(fwd_a), .fwd_b(fwd_b), .id_byp_a(id_byp_a),
    .pc_hold(pc_hold), .ctrl_zero(ctrl_zero)
);

// File: tb/hazard_fwd_unit_tb.sv
module hazard_fwd_unit_tb_top;
    localparam int AW = 5;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0;
    logic [AW-1:0] ex_rd = '0, mem_rd = '0, wb_rd = '0;
    logic ex_memrd = 1'b0, mem_we = 1'b0, wb_we = 1'b0;
    logic [1:0] fwd_a, fwd_b;
    logic id_byp_a, id_byp_b, pc_hold, ifid_hold, ctrl_zero;
    int total = 0, bad = 0;
    logic prev_stall = 1'b0;

    always #10 clk = ~clk;

    hazard_fwd_unit #(.REG_AW(AW)) dut_i (.*);

    function automatic logic [1:0] exp_sel(input logic [AW-1:0] s);
        if (mem_we && mem_rd != 0 && mem_rd == s) return 2'b10;
        if (wb_we && wb_rd != 0 && wb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic exp_byp(input logic [AW-1:0] s);
        return wb_we && wb_rd != 0 && wb_rd == s;
    endfunction

    function automatic logic exp_haz();
        return ex_memrd && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
    endfunction

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Inputs are already applied; sample mid-low-phase, then let the edge pass.
    task automatic check_cycle();
        logic st;
        #5;
        st = !prev_stall && exp_haz();
        chk("R1 R2 R3 R4 fwd_a", fwd_a, exp_sel(ex_rs1));
        chk("R1 R2 R3 R4 fwd_b", fwd_b, exp_sel(ex_rs2));
        chk("R5 id_byp_a", {1'b0, id_byp_a}, {1'b0, exp_byp(id_rs1)});
        chk("R5 id_byp_b", {1'b0, id_byp_b}, {1'b0, exp_byp(id_rs2)});
        chk("R6 R7 R8 pc_hold", {1'b0, pc_hold}, {1'b0, st});
        chk("R6 R7 R8 ifid_hold", {1'b0, ifid_hold}, {1'b0, st});
        chk("R6 R7 R8 ctrl_zero", {1'b0, ctrl_zero}, {1'b0, st});
        @(posedge clk);
        prev_stall = st;
        @(negedge clk);
    endtask

    task automatic drive(input logic [AW-1:0] i1, i2, e1, e2, erd, input logic emr,
                         input logic [AW-1:0] mrd, input logic mwe,
                         input logic [AW-1:0] wrd, input logic wwe);
        id_rs1 = i1; id_rs2 = i2; ex_rs1 = e1; ex_rs2 = e2; ex_rd = erd;
        ex_memrd = emr; mem_rd = mrd; mem_we = mwe; wb_rd = wrd; wb_we = wwe;
    endtask

    initial begin
        int seed = 17;
        void'($urandom(seed));
        @(negedge clk);
        // R9 reset state with all inputs zero
        check_cycle();
        rst_n = 1'b1;
        @(negedge clk);
        check_cycle();
        // R1 memory-stage bypass on A
        drive(0, 0, 3, 4, 0, 0, 3, 1, 0, 0); check_cycle();
        // R2 write-back bypass on B
        drive(0, 0, 3, 4, 0, 0, 0, 0, 4, 1); check_cycle();
        // R3 both match, memory stage wins
        drive(0, 0, 6, 6, 0, 0, 6, 1, 6, 1); check_cycle();
        // R4 register 0 and low enables
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 1); check_cycle();
        drive(0, 0, 5, 5, 0, 0, 5, 0, 5, 0); check_cycle();
        // R5 decode write-before-read
        drive(7, 8, 0, 0, 0, 0, 0, 0, 8, 1); check_cycle();
        // R7 load to r0, non-load match
        drive(0, 9, 0, 0, 0, 1, 0, 0, 0, 0); check_cycle();
        drive(9, 0, 0, 0, 9, 0, 0, 0, 0, 0); check_cycle();
        // R6 R8 persistent hazard: stall, held, stall
        drive(2, 5, 0, 0, 2, 1, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) check_cycle();
        // stall together with bypass on both operands
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); check_cycle();
        drive(1, 3, 1, 2, 3, 1, 1, 1, 2, 1); check_cycle();
        // random phase with small register range
        for (int n = 0; n < 400; n++) begin
            drive($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                  $urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom_range(0, 1)),
                  $urandom_range(0, 3), 1'($urandom_range(0, 1)),
                  $urandom_range(0, 3), 1'($urandom_range(0, 1)));
            check_cycle();
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++; bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule